// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel hung off a timer counter. Software loads a 16-bit compare value over an 8-bit bus in two byte writes: the upper byte is parked in a shared holding byte, and the lower byte write moves both bytes into a 16-bit staging register in one cycle. A second register, the live compare value, feeds the equality comparator. The live value is loaded from the staging register at a point chosen by the waveform mode: at once in the plain counting modes, or on a counter-top or counter-bottom strobe in the pulse-width modes.

While the timer clock enable is high and the counter input equals the live value, the channel emits a one-cycle match event to the waveform logic. On the same edge it sets a sticky compare flag, so the flag becomes visible one timer tick after the equality began. The flag drives an interrupt request when enabled. It clears when the interrupt is acknowledged or when software writes a one to it. On each match the channel's output pin toggles, clears or sets, as the 2-bit output action selects. A build option lets the channel supply its live value as the counter's period limit.

Top module: `cmp_channel`

## Requirements
- R1: After reset the flag, interrupt request, pin, holding byte, staging register and live compare value are all zero.
- R2: On a clock edge where `tick` is 1 and `count` equals `cmp_value`, `match` is 1 for that cycle and `flag` becomes 1 after the edge. With `tick` at 0, equality has no effect.
- R3: `irq` is 1 exactly when `flag` is 1 and `int_en` is 1.
- R4: A cycle with `irq_ack` at 1 clears `flag` at the next edge.
- R5: A cycle with `flag_wr` at 1 and `wdata[0]` at 1 clears `flag`. With `wdata[0]` at 0 the flag is unchanged.
- R6: A `wr_hi` write only stores `wdata` in the holding byte. The staging and live values are unchanged.
- R7: A `wr_lo` write loads the staging register with {holding byte, `wdata`} on that edge.
- R8: In modes 0, 4, 12 and 13 (`mode` is 4 bits), the live value takes the new staging value on the same edge as the low-byte write.
- R9: In modes 8 and 9 the live value loads from staging only on an edge with `tick` and `at_bottom` both 1. In every other mode outside R8, it loads only on an edge with `tick` and `at_top` both 1. At any other edge it holds.
- R10: On a match edge, `pin` does nothing for `out_mode` 00, toggles for 01, goes to 0 for 10 and goes to 1 for 11. `pin_en` is 1 whenever `out_mode` is not 00.
- R11: When a flag set from R2 and a clear from R4 or R5 fall on the same edge, the set wins.
- R12: With `PERIOD_SRC` = 1, `period_limit` equals `cmp_value`. With `PERIOD_SRC` = 0, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| count | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at its top value |
| at_bottom | input | 1 | Counter is at zero |
| mode | input | 4 | Waveform mode selecting the update point |
| out_mode | input | 2 | Pin action on match |
| wdata | input | 8 | Processor write data |
| wr_hi | input | 1 | Upper byte write strobe |
| wr_lo | input | 1 | Lower byte write strobe |
| flag_wr | input | 1 | Flag write strobe (one in wdata[0] clears) |
| int_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge |
| match | output | 1 | Match event to the waveform logic |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| pin | output | 1 | Compare output pin value |
| pin_en | output | 1 | Pin driven by the channel |
| cmp_value | output | 16 | Live compare value |
| period_limit | output | 16 | Counter top value from this channel |

## Verification
The bench builds the channel with an 8-bit bus, and therefore a 16-bit compare value, and with `PERIOD_SRC` set to 1. With this build the period output mirrors the live value and can be checked at each update point. The 16-bit width lets the tests pick compare values whose upper and lower bytes differ, so a byte swap or a lost holding byte shows up at the ports. Because the counter value is driven directly, each match, the tick gating and each deferred update can be placed on a chosen cycle.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_TOG  = 2'b01,
      ACT_LOW  = 2'b10,
      ACT_HIGH = 2'b11
   } pin_act_e;

   typedef enum logic [1:0] {
      LOAD_NOW = 2'b00,
      LOAD_TOP = 2'b01,
      LOAD_BOT = 2'b10
   } load_pt_e;

   function automatic load_pt_e load_point(input logic [3:0] m);
      load_pt_e r;
      case (m)
         4'd0, 4'd4, 4'd12, 4'd13: r = LOAD_NOW;
         4'd8, 4'd9:               r = LOAD_BOT;
         default:                  r = LOAD_TOP;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cmp_wr_path.sv
module cmp_wr_path #(
   parameter int BUS_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hi_we,
   input  logic                 lo_we,
   input  logic [BUS_W-1:0]     wdata,
   output logic [2*BUS_W-1:0]   stage_q,
   output logic [2*BUS_W-1:0]   stage_d
);
   localparam int VAL_W = 2 * BUS_W;

   logic [BUS_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (hi_we) begin
         hold_q <= wdata;
      end
   end

   always_comb begin
      stage_d = stage_q;
      if (lo_we) begin
         stage_d = {hold_q, wdata};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= {VAL_W{1'b0}};
      end else begin
         stage_q <= stage_d;
      end
   end
endmodule

// File: rtl/cmp_live_reg.sv
module cmp_live_reg
   import cmp_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             at_top,
   input  logic             at_bottom,
   input  logic [3:0]       mode,
   input  logic [VAL_W-1:0] stage_q,
   input  logic [VAL_W-1:0] stage_d,
   output logic [VAL_W-1:0] live_q
);
   load_pt_e   pt;
   logic       strobe;

   always_comb begin
      pt = load_point(mode);
      case (pt)
         LOAD_TOP: strobe = tick & at_top;
         LOAD_BOT: strobe = tick & at_bottom;
         default:  strobe = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (pt == LOAD_NOW) begin
         live_q <= stage_d;
      end else if (strobe) begin
         live_q <= stage_q;
      end
   end
endmodule

// File: rtl/cmp_flag_ctl.sv
module cmp_flag_ctl #(
   parameter int VAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [VAL_W-1:0] count,
   input  logic [VAL_W-1:0] live,
   input  logic             int_en,
   input  logic             ack,
   input  logic             clr_we,
   input  logic             clr_bit,
   output logic             evt,
   output logic             flag_q,
   output logic             irq
);
   logic equal;
   logic clear;

   always_comb begin
      equal = (count == live);
      evt   = tick & equal;
      clear = ack | (clr_we & clr_bit);
      irq   = flag_q & int_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (evt) begin
         flag_q <= 1'b1;
      end else if (clear) begin
         flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cmp_pin_drv.sv
module cmp_pin_drv
   import cmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt,
   input  logic [1:0] out_mode,
   output logic       pin_q,
   output logic       pin_en
);
   pin_act_e act;
   logic     pin_d;

   always_comb begin
      act    = pin_act_e'(out_mode);
      pin_en = (act != ACT_NONE);
      pin_d  = pin_q;
      if (evt) begin
         case (act)
            ACT_TOG:  pin_d = ~pin_q;
            ACT_LOW:  pin_d = 1'b0;
            ACT_HIGH: pin_d = 1'b1;
            default:  pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else begin
         pin_q <= pin_d;
      end
   end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
   parameter int BUS_W      = 8,
   parameter bit PERIOD_SRC = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [2*BUS_W-1:0]   count,
   input  logic                 at_top,
   input  logic                 at_bottom,
   input  logic [3:0]           mode,
   input  logic [1:0]           out_mode,
   input  logic [BUS_W-1:0]     wdata,
   input  logic                 wr_hi,
   input  logic                 wr_lo,
   input  logic                 flag_wr,
   input  logic                 int_en,
   input  logic                 irq_ack,
   output logic                 match,
   output logic                 flag,
   output logic                 irq,
   output logic                 pin,
   output logic                 pin_en,
   output logic [2*BUS_W-1:0]   cmp_value,
   output logic [2*BUS_W-1:0]   period_limit
);
   localparam int VAL_W = 2 * BUS_W;

   if (BUS_W < 2 || BUS_W > 32) begin : g_bad_width
      $error("cmp_channel: BUS_W must lie in 2..32");
   end

   logic [VAL_W-1:0] stage_q;
   logic [VAL_W-1:0] stage_d;

   cmp_wr_path #(.BUS_W(BUS_W)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_we   (wr_hi),
      .lo_we   (wr_lo),
      .wdata   (wdata),
      .stage_q (stage_q),
      .stage_d (stage_d)
   );

   cmp_live_reg #(.VAL_W(VAL_W)) u_live (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .at_top    (at_top),
      .at_bottom (at_bottom),
      .mode      (mode),
      .stage_q   (stage_q),
      .stage_d   (stage_d),
      .live_q    (cmp_value)
   );

   cmp_flag_ctl #(.VAL_W(VAL_W)) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .count   (count),
      .live    (cmp_value),
      .int_en  (int_en),
      .ack     (irq_ack),
      .clr_we  (flag_wr),
      .clr_bit (wdata[0]),
      .evt     (match),
      .flag_q  (flag),
      .irq     (irq)
   );

   cmp_pin_drv u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (match),
      .out_mode (out_mode),
      .pin_q    (pin),
      .pin_en   (pin_en)
   );

   if (PERIOD_SRC) begin : g_period
      assign period_limit = cmp_value;
   end else begin : g_no_period
      assign period_limit = '0;
   end
endmodule

// File: rtl/cmp_channel_chk.sv
module cmp_channel_chk #(
   parameter int VAL_W = 16,
   parameter int BUS_W = 8,
   parameter bit PERIOD_SRC = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [VAL_W-1:0] count,
   input logic             at_top,
   input logic             at_bottom,
   input logic [3:0]       mode,
   input logic [1:0]       out_mode,
   input logic [BUS_W-1:0] wdata,
   input logic             wr_hi,
   input logic             wr_lo,
   input logic             flag_wr,
   input logic             int_en,
   input logic             irq_ack,
   input logic             match,
   input logic             flag,
   input logic             irq,
   input logic             pin,
   input logic [VAL_W-1:0] cmp_value,
   input logic [VAL_W-1:0] period_limit,
   input logic [VAL_W-1:0] stage_q
);
   logic now_mode;
   logic bot_mode;
   assign now_mode = (mode == 4'd0) || (mode == 4'd4) || (mode == 4'd12) || (mode == 4'd13);
   assign bot_mode = (mode == 4'd8) || (mode == 4'd9);

   a_r2_equal_gives_match: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == cmp_value) |-> match);
   a_r2_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> flag);
   a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && int_en));
   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !match) |=> !flag);
   a_r5_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wdata[0] && !match) |=> !flag);
   a_r6_hi_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> $stable(stage_q));
   a_r7_lo_loads_low: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (stage_q[BUS_W-1:0] == $past(wdata)));
   a_r8_now_follows: assert property (@(posedge clk) disable iff (!rst_n)
      now_mode |=> (cmp_value == stage_q));
   a_r9_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!now_mode && !(tick && (bot_mode ? at_bottom : at_top))) |=> $stable(cmp_value));
   a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (match && out_mode == 2'b01) |=> (pin != $past(pin)));
   a_r12_period: assert property (@(posedge clk) disable iff (!rst_n)
      PERIOD_SRC |-> (period_limit == cmp_value));
endmodule

bind cmp_channel cmp_channel_chk #(.VAL_W(2*BUS_W), .BUS_W(BUS_W), .PERIOD_SRC(PERIOD_SRC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .count        (count),
   .at_top       (at_top),
   .at_bottom    (at_bottom),
   .mode         (mode),
   .out_mode     (out_mode),
   .wdata        (wdata),
   .wr_hi        (wr_hi),
   .wr_lo        (wr_lo),
   .flag_wr      (flag_wr),
   .int_en       (int_en),
   .irq_ack      (irq_ack),
   .match        (match),
   .flag         (flag),
   .irq          (irq),
   .pin          (pin),
   .cmp_value    (cmp_value),
   .period_limit (period_limit),
   .stage_q      (stage_q)
);

// File: tb/cmp_channel_tb_top.sv
module cmp_channel_tb_top;
   localparam logic [15:0] IDLE = 16'hFFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic [15:0] count = IDLE;
   logic        at_top = 1'b0;
   logic        at_bottom = 1'b0;
   logic [3:0]  mode = 4'd0;
   logic [1:0]  out_mode = 2'b00;
   logic [7:0]  wdata = 8'h00;
   logic        wr_hi = 1'b0;
   logic        wr_lo = 1'b0;
   logic        flag_wr = 1'b0;
   logic        int_en = 1'b0;
   logic        irq_ack = 1'b0;
   logic        match, flag, irq, pin, pin_en;
   logic [15:0] cmp_value, period_limit;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cmp_channel #(.BUS_W(8), .PERIOD_SRC(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
      .at_top(at_top), .at_bottom(at_bottom), .mode(mode), .out_mode(out_mode),
      .wdata(wdata), .wr_hi(wr_hi), .wr_lo(wr_lo), .flag_wr(flag_wr),
      .int_en(int_en), .irq_ack(irq_ack), .match(match), .flag(flag),
      .irq(irq), .pin(pin), .pin_en(pin_en), .cmp_value(cmp_value),
      .period_limit(period_limit)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_hi(input logic [7:0] b);
      wr_hi = 1'b1; wdata = b;
      @(negedge clk);
      wr_hi = 1'b0;
   endtask

   task automatic write_lo(input logic [7:0] b);
      wr_lo = 1'b1; wdata = b;
      @(negedge clk);
      wr_lo = 1'b0;
   endtask

   task automatic hit(input logic [15:0] v);
      count = v;
      #1 check("R2 match", match, tick);
      @(negedge clk);
      count = IDLE;
   endtask

   task automatic drop_flag();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 flag", flag, 0);
      check("R1 irq", irq, 0);
      check("R1 pin", pin, 0);
      check("R1 value", cmp_value, 16'h0000);
   endtask

   task automatic t_write();
      write_hi(8'h12);
      check("R6 hi only", cmp_value, 16'h0000);
      write_lo(8'h34);
      check("R7 R8 value", cmp_value, 16'h1234);
      check("R12 period", period_limit, 16'h1234);
   endtask

   task automatic t_flag();
      int_en = 1'b0;
      count = 16'h1234;
      #1 check("R2 no flag yet", flag, 0);
      @(negedge clk);
      count = IDLE;
      check("R2 flag set", flag, 1);
      check("R3 irq off", irq, 0);
      int_en = 1'b1;
      #1 check("R3 irq on", irq, 1);
      drop_flag();
      check("R4 ack clears", flag, 0);
      check("R4 irq low", irq, 0);
   endtask

   task automatic t_swclr();
      hit(16'h1234);
      flag_wr = 1'b1; wdata = 8'h00;
      @(negedge clk);
      check("R5 zero write", flag, 1);
      wdata = 8'h01;
      @(negedge clk);
      flag_wr = 1'b0;
      check("R5 one write", flag, 0);
   endtask

   task automatic t_tick();
      tick = 1'b0;
      count = 16'h1234;
      #1 check("R2 no match w/o tick", match, 0);
      @(negedge clk);
      count = IDLE;
      tick = 1'b1;
      check("R2 no flag w/o tick", flag, 0);
   endtask

   task automatic t_priority();
      irq_ack = 1'b1;
      hit(16'h1234);
      irq_ack = 1'b0;
      check("R11 set wins", flag, 1);
      drop_flag();
   endtask

   task automatic t_pwm();
      mode = 4'd5;
      write_hi(8'h20); write_lo(8'h00);
      check("R9 top mode holds", cmp_value, 16'h1234);
      at_bottom = 1'b1; @(negedge clk); at_bottom = 1'b0;
      check("R9 bottom ignored", cmp_value, 16'h1234);
      tick = 1'b0; at_top = 1'b1; @(negedge clk); at_top = 1'b0; tick = 1'b1;
      check("R9 top w/o tick", cmp_value, 16'h1234);
      at_top = 1'b1; @(negedge clk); at_top = 1'b0;
      check("R9 top load", cmp_value, 16'h2000);
      mode = 4'd8;
      write_hi(8'h30); write_lo(8'h01);
      at_top = 1'b1; @(negedge clk); at_top = 1'b0;
      check("R9 top ignored", cmp_value, 16'h2000);
      at_bottom = 1'b1; @(negedge clk); at_bottom = 1'b0;
      check("R9 bottom load", cmp_value, 16'h3001);
      check("R12 period follows", period_limit, 16'h3001);
   endtask

   task automatic t_pin();
      mode = 4'd0;
      @(negedge clk);
      check("R8 now mode", cmp_value, 16'h3001);
      out_mode = 2'b01;
      #1 check("R10 pin_en", pin_en, 1);
      hit(16'h3001);
      check("R10 toggle up", pin, 1);
      hit(16'h3001);
      check("R10 toggle down", pin, 0);
      out_mode = 2'b11;
      hit(16'h3001);
      check("R10 set", pin, 1);
      out_mode = 2'b10;
      hit(16'h3001);
      check("R10 clear", pin, 0);
      out_mode = 2'b11;
      hit(16'h3001);
      out_mode = 2'b00;
      #1 check("R10 pin_en off", pin_en, 0);
      hit(16'h3001);
      check("R10 none holds", pin, 1);
      drop_flag();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_flag();
      t_swclr();
      t_tick();
      t_priority();
      t_pwm();
      t_pin();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule